// File: doc/BRIEF.md
# Armed circular-buffer capture recorder

This block records samples of a data bus into on-chip storage around a trigger event. Software programs a window size and a pre-trigger count, then arms the recorder through a small register port. From the arming write until the trigger, the recorder writes every sample into a circular buffer. This keeps the most recent history. When the hit input rises, the recorder records the remaining post-trigger samples and stops. Software then reads the window back oldest first through the same register port.

The window length and pre-trigger count are taken when the recorder is armed. A later register write therefore cannot disturb a capture in progress. A trigger can come before enough history has been written. In that case the window still ends at the same place, and a valid-count register reports how many of its samples are real.

Top module: `capture_recorder`

## Requirements
- R1: After reset, STATUS (address 3) reads 0 and VALID (address 4) reads 0. STATUS bit 0 is done and bit 1 is busy (armed or post-trigger).
- R2: The hit input has no effect while the recorder is not armed. This holds both after reset and after a capture has finished: STATUS and VALID keep their values.
- R3: While armed, only a rising edge of hit (low in the previous cycle, high now) starts the post-trigger phase. A hit that is already high at arming must first fall.
- R4: Let S be the effective size and O the effective offset. The sample present in the hit cycle is the first of S−O post-trigger samples. After the last of them, STATUS reads 1 (done, not busy).
- R5: Reading DATA (address 5) returns the window oldest first. The window is the S samples ending with the last post-trigger sample, so the hit sample is the entry at index O.
- R6: Each DATA read advances the read pointer modulo the buffer depth. With S equal to the depth, reads past the end of the window repeat it from the start.
- R7: VALID reads min(P, O) + (S − O), where P is the number of samples written between arming and the hit cycle.
- R8: A SIZE of 0 acts as 1 and a SIZE above the depth acts as the depth. An OFFSET at or above the effective size acts as size − 1.
- R9: Writing 1 to bit 0 of CTRL (address 0) arms the recorder from any state. It clears done and VALID and restarts the pre-trigger count, and STATUS then reads 2.
- R10: A read strobe returns its data on reg_rdata with reg_rvalid high in the following cycle. SIZE (1) and OFFSET (2) read back the raw written values.
- R11: SIZE and OFFSET writes made while a capture is running do not change that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | DATA_W | Data bus being recorded |
| hit_i | input | 1 | Trigger input |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | REG_W | Read data, one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |

## Verification
Register reads complete one cycle after their strobe. The bench lowers the strobe at the next falling edge and samples reg_rdata there.

A sample driven before clock edge E+1+n is stored at that edge, where E is the arming edge. The bench logs each sample by that index and drives the hit at index j. Done becomes visible on the edge that stores sample j+S−O−1, and the read pointer settles one edge later. The bench therefore waits three spare cycles before reading STATUS, VALID and the window. It compares only the entries that VALID declares real against its own log.

// File: rtl/rec_pkg.sv
package rec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_POST,
    ST_DONE
  } seq_state_t;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_SIZE   = 3'd1;
  localparam logic [2:0] A_OFFSET = 3'd2;
  localparam logic [2:0] A_STATUS = 3'd3;
  localparam logic [2:0] A_VALID  = 3'd4;
  localparam logic [2:0] A_DATA   = 3'd5;
endpackage

// File: rtl/rec_store.sv
module rec_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  // simple dual-port array, registered read: maps onto block RAM
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/rec_sequencer.sv
module rec_sequencer
  import rec_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] size_eff_i,
  input  logic [CNT_W-1:0] off_eff_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] valid_o,
  output logic             fin_o,
  output logic [AW-1:0]    start_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  seq_state_t       state;
  logic [AW-1:0]    wr_ptr;
  logic [CNT_W-1:0] pre_cnt, post_cnt, post_tot, size_lat, off_lat, valid_q;
  logic             hit_q, fin_q;
  logic [AW-1:0]    start_q;

  logic             hit_rise;
  logic [CNT_W-1:0] pre_kept;
  logic             last_wr;
  logic [AW-1:0]    start_calc;

  assign hit_rise   = hit_i & ~hit_q;
  assign pre_kept   = (pre_cnt < off_lat) ? pre_cnt : off_lat;
  assign last_wr    = (state == ST_ARMED && hit_rise && post_tot == CNT_W'(1)) ||
                      (state == ST_POST && (post_cnt + CNT_W'(1)) == post_tot);
  assign start_calc = wr_ptr + AW'(1) - size_lat[AW-1:0];

  assign wr_en_o   = (state == ST_ARMED) || (state == ST_POST);
  assign wr_addr_o = wr_ptr;
  assign busy_o    = wr_en_o;
  assign done_o    = (state == ST_DONE);
  assign valid_o   = valid_q;
  assign fin_o     = fin_q;
  assign start_o   = start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_ptr   <= '0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      post_tot <= CNT_W'(1);
      size_lat <= CNT_W'(1);
      off_lat  <= '0;
      valid_q  <= '0;
      hit_q    <= 1'b0;
      fin_q    <= 1'b0;
      start_q  <= '0;
    end else begin
      hit_q <= hit_i;
      fin_q <= 1'b0;
      if (wr_en_o) wr_ptr <= wr_ptr + AW'(1);
      if (arm_i) begin
        state    <= ST_ARMED;
        pre_cnt  <= '0;
        post_cnt <= '0;
        valid_q  <= '0;
        size_lat <= size_eff_i;
        off_lat  <= off_eff_i;
        post_tot <= size_eff_i - off_eff_i;
      end else begin
        case (state)
          ST_ARMED: begin
            if (hit_rise) begin
              post_cnt <= CNT_W'(1);
              valid_q  <= pre_kept + post_tot;
              state    <= last_wr ? ST_DONE : ST_POST;
            end else if (pre_cnt != DEPTH_C) begin
              pre_cnt <= pre_cnt + CNT_W'(1);
            end
          end
          ST_POST: begin
            post_cnt <= post_cnt + CNT_W'(1);
            if (last_wr) state <= ST_DONE;
          end
          default: ;
        endcase
        if (last_wr) begin
          fin_q   <= 1'b1;
          start_q <= start_calc;
        end
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !arm_i) |=> state == ST_IDLE); // R2
  AST_POST_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POST) |-> (post_cnt < post_tot)); // R4
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !arm_i) |=> (state == ST_DONE && $stable(wr_ptr))); // R4
  AST_VALID_BOUND: assert property (@(posedge clk) disable iff (rst)
    valid_q <= size_lat); // R7
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (state == ST_ARMED && valid_q == '0)); // R9
endmodule

// File: rtl/rec_regs.sv
module rec_regs
  import rec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH),
  parameter int CNT_W  = AW + 1,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  valid_i,
  input  logic              fin_i,
  input  logic [AW-1:0]     start_i,
  input  logic [DATA_W-1:0] mem_q_i,
  output logic              arm_o,
  output logic [CNT_W-1:0]  size_eff_o,
  output logic [CNT_W-1:0]  off_eff_o,
  output logic              mem_rd_en_o,
  output logic [AW-1:0]     mem_rd_addr_o,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_rvalid
);
  localparam logic [REG_W-1:0] DEPTH_R = REG_W'(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [REG_W-1:0] size_raw, off_raw, misc_q;
  logic [AW-1:0]    rd_ptr;
  logic             sel_data_q, rvalid_q;
  logic             data_rd;

  assign arm_o   = reg_wr && reg_addr == A_CTRL && reg_wdata[0];
  assign data_rd = reg_rd && reg_addr == A_DATA;

  always_comb begin
    if (size_raw == '0)          size_eff_o = CNT_W'(1);
    else if (size_raw > DEPTH_R) size_eff_o = DEPTH_C;
    else                         size_eff_o = size_raw[CNT_W-1:0];
  end

  always_comb begin
    if (off_raw >= REG_W'(size_eff_o)) off_eff_o = size_eff_o - CNT_W'(1);
    else                               off_eff_o = off_raw[CNT_W-1:0];
  end

  assign mem_rd_en_o   = data_rd;
  assign mem_rd_addr_o = rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      size_raw <= REG_W'(1);
      off_raw  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_SIZE)   size_raw <= reg_wdata;
      if (reg_addr == A_OFFSET) off_raw  <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_ptr <= '0;
    else if (fin_i)   rd_ptr <= start_i;
    else if (data_rd) rd_ptr <= rd_ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      misc_q     <= '0;
      sel_data_q <= 1'b0;
      rvalid_q   <= 1'b0;
    end else begin
      rvalid_q   <= reg_rd;
      sel_data_q <= data_rd;
      if (reg_rd) begin
        case (reg_addr)
          A_SIZE:   misc_q <= size_raw;
          A_OFFSET: misc_q <= off_raw;
          A_STATUS: misc_q <= REG_W'({busy_i, done_i});
          A_VALID:  misc_q <= REG_W'(valid_i);
          default:  misc_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata  = sel_data_q ? REG_W'(mem_q_i) : misc_q;
  assign reg_rvalid = rvalid_q;

  AST_SIZE_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (size_eff_o != '0 && size_eff_o <= DEPTH_C && off_eff_o < size_eff_o)); // R8
  AST_RDPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !fin_i) |=> rd_ptr == $past(rd_ptr) + AW'(1)); // R6
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R10
endmodule

// File: rtl/capture_recorder.sv
module capture_recorder #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              hit_i,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_rvalid
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic             arm, wr_en, busy, done, fin, mem_rd_en;
  logic [AW-1:0]    wr_addr, start, mem_rd_addr;
  logic [CNT_W-1:0] size_eff, off_eff, valid;
  logic [DATA_W-1:0] mem_q;

  rec_sequencer #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .arm_i(arm), .hit_i(hit_i),
    .size_eff_i(size_eff), .off_eff_i(off_eff),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .busy_o(busy), .done_o(done),
    .valid_o(valid), .fin_o(fin), .start_o(start)
  );

  rec_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(sample_i),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_q(mem_q)
  );

  rec_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .busy_i(busy), .done_i(done),
    .valid_i(valid), .fin_i(fin), .start_i(start), .mem_q_i(mem_q),
    .arm_o(arm), .size_eff_o(size_eff), .off_eff_o(off_eff),
    .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );
endmodule

// File: tb/capture_recorder_bench.sv
module capture_recorder_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int REG_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] sample_i = '0;
  logic              hit_i = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic              reg_rd = 1'b0;
  logic [REG_W-1:0]  reg_rdata;
  logic              reg_rvalid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int hist [64];
  int last_s, last_j, last_p;

  always #2 clk = ~clk;

  capture_recorder #(.DATA_W(DATA_W), .DEPTH(DEPTH), .REG_W(REG_W)) u_capture_recorder (
    .clk(clk), .rst(rst), .sample_i(sample_i), .hit_i(hit_i),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  function automatic int eff_size(int raw);
    if (raw == 0) return 1;
    if (raw > DEPTH) return DEPTH;
    return raw;
  endfunction

  function automatic int eff_off(int raw, int s);
    return (raw >= s) ? s - 1 : raw;
  endfunction

  function automatic int exp_valid(int j, int o, int p);
    return ((j < o) ? j : o) + p;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = REG_W'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output int val);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    val = int'(reg_rdata);
    chk("R10 rvalid", int'(reg_rvalid), 1);
  endtask

  task automatic pulse_hit();
    @(negedge clk); hit_i = 1'b1;
    @(negedge clk); hit_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_cap(int sraw, int oraw, int j, bit pre_high, bit double_arm, bit mid_cfg);
    int s, o, p, v, r;
    s = eff_size(sraw); o = eff_off(oraw, s); p = s - o;
    reg_write(3'd1, sraw);
    reg_write(3'd2, oraw);
    if (double_arm) begin
      reg_write(3'd0, 1);
      for (int k = 0; k < 5; k++) begin
        sample_i = DATA_W'($urandom);
        @(negedge clk);
      end
    end
    if (pre_high) hit_i = 1'b1;
    reg_write(3'd0, 1);
    for (int n = 0; n < j + p + 3; n++) begin
      sample_i = DATA_W'($urandom);
      hist[n] = int'(sample_i);
      hit_i = (n == j) || (pre_high && n < 2);
      if (mid_cfg && n == 1) begin
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = REG_W'(DEPTH);
      end else begin
        reg_wr = 1'b0;
      end
      @(negedge clk);
    end
    hit_i = 1'b0;
    reg_wr = 1'b0;
    last_s = s; last_j = j; last_p = p;
    reg_read(3'd3, r);
    chk("R4 done status", r, 1);
    reg_read(3'd4, v);
    chk("R7 valid count", v, exp_valid(j, o, p));
    for (int k = 0; k < s; k++) begin
      reg_read(3'd5, r);
      if (k >= s - v) begin
        if (pre_high)     chk("R3 edge-only hit sample", r, hist[j + p - s + k]);
        else if (mid_cfg) chk("R11 latched config sample", r, hist[j + p - s + k]);
        else              chk("R5 window sample", r, hist[j + p - s + k]);
      end
    end
  endtask

  initial begin
    int r, v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    reg_read(3'd3, r); chk("R1 reset status", r, 0);
    reg_read(3'd4, r); chk("R1 reset valid", r, 0);

    pulse_hit();
    reg_read(3'd3, r); chk("R2 idle hit status", r, 0);
    reg_read(3'd4, r); chk("R2 idle hit valid", r, 0);

    run_cap(8, 3, 6, 0, 0, 0);
    pulse_hit();
    reg_read(3'd3, r); chk("R2 done hit status", r, 1);
    reg_read(3'd4, r); chk("R2 done hit valid", r, 8);

    reg_write(3'd0, 1);
    reg_read(3'd3, r); chk("R9 rearm status", r, 2);
    reg_read(3'd4, r); chk("R9 rearm valid", r, 0);

    run_cap(10, 6, 2, 0, 0, 0);
    run_cap(5, 2, 4, 1, 0, 0);
    run_cap(6, 2, 5, 0, 0, 1);
    reg_read(3'd1, r); chk("R10 size readback", r, DEPTH);
    reg_write(3'd2, 7);
    reg_read(3'd2, r); chk("R10 offset readback", r, 7);
    run_cap(0, 3, 4, 0, 0, 0);
    reg_read(3'd4, r); chk("R8 size zero valid", r, 1);
    run_cap(40, 30, 20, 0, 0, 0);
    reg_read(3'd4, r); chk("R8 size clamp valid", r, DEPTH);
    run_cap(7, 3, 1, 0, 1, 0);
    reg_read(3'd4, r); chk("R9 double arm valid", r, 5);

    run_cap(DEPTH, 4, 10, 0, 0, 0);
    for (int k = 0; k < DEPTH; k++) begin
      reg_read(3'd5, v);
      chk("R6 wrap sample", v, hist[last_j + last_p - last_s + k]);
    end

    for (int t = 0; t < 12; t++) begin
      run_cap($urandom_range(0, 20), $urandom_range(0, 22), $urandom_range(0, 20), 0, 0, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule